// File: doc/BRIEF.md
# Float RGB to R11G11B10 Packed Colour Encoder

The block takes three IEEE single-precision colour components and packs them into one 32-bit word of unsigned small floats. Red and green each become an 11-bit float (5 exponent bits, 6 mantissa bits). Blue becomes a 10-bit float (5 exponent bits, 5 mantissa bits). All three fields use exponent bias 15, and none has a sign bit. The three components are converted in parallel, each by its own path. The results are placed side by side, and the word is registered together with a valid flag.

Because the fields cannot hold a sign, every negative finite value clamps to zero. Positive infinity and NaNs of either sign keep their special encodings. Rounding is always toward zero. An out-of-range finite value saturates to the largest finite field value and never becomes infinity. A value below the normal range becomes a field denormal, or zero if it is smaller still. Typical use is a colour write path that stores high-dynamic-range pixels in a compact 32-bit format.

Top module: `rgb_f32_pack`

## Requirements
- R1: Red sits in bits 10:0, green in bits 21:11 and blue in bits 31:22. In each field the 5-bit exponent sits directly above the mantissa (6 bits for red and green, 5 for blue). A positive normal input whose result fits the field encodes with field exponent = float32 exponent − 112, and its mantissa is the top fraction bits of the input.
- R2: A negative finite input, including negative zero and negative denormals, encodes as a field of all zeros.
- R3: −Inf encodes as zero. +Inf encodes as exponent 31 with mantissa zero (red 0x7C0, blue 0x3E0).
- R4: A NaN of either sign and any payload encodes as exponent 31 with only the top mantissa bit set (red/green 0x7E0, blue 0x3F0).
- R5: A finite value at or above 2^16 saturates to exponent 30 with mantissa all ones (red/green 0x7BF, blue 0x3DF). Finite inputs never produce exponent 31.
- R6: Mantissa bits below the field's width are discarded, so the result never rounds up (e.g. 1.99999988 gives red 0x3FF, not 2.0).
- R7: A positive value below 2^-14 encodes with exponent 0 and mantissa floor(v·2^(14+M)), where M is the field's mantissa width. A float32 denormal or a value below the smallest field denormal encodes as zero.
- R8: Each field depends only on its own component. No denormal, saturated or special result changes the bits of a neighbouring field.
- R9: valid_o is valid_i delayed by one clock cycle. The packed word of a valid input appears on packed_o in the same cycle as the matching valid_o.
- R10: While valid_i is low, packed_o holds its last value, whatever the component inputs do.
- R11: Asserting rst_ni low clears packed_o and valid_o at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Component inputs are valid this cycle |
| red_i | input | 32 | Red component, IEEE single precision |
| green_i | input | 32 | Green component, IEEE single precision |
| blue_i | input | 32 | Blue component, IEEE single precision |
| valid_o | output | 1 | packed_o carries a new word |
| packed_o | output | 32 | Packed blue/green/red small-float word |

## Verification
The bench aims at the edges between encoding regions. The largest finite values 65024 and 64512 are tested, and a design that rebiases off by one would turn them into infinity. A NaN with the sign bit set is tested, and a design that checks the sign first would clamp it to zero. Values at 2^-14 and just below it are tested to expose a wrong denormal shift amount. Values whose discarded fraction bits are all ones are tested to catch any rounding up. A small red denormal is sent next to zero and infinity in the other fields to catch bits spilling across field boundaries. A long pseudo-random sweep compares every field with an independent real-number model.

// File: rtl/rgb_pack_pkg.sv
package rgb_pack_pkg;

  localparam int unsigned F32_W      = 32;
  localparam int unsigned F32_EXP_W  = 8;
  localparam int unsigned F32_FRAC_W = 23;
  localparam int unsigned F32_BIAS   = 127;

  typedef struct packed {
    logic                  sign;
    logic [F32_EXP_W-1:0]  exp;
    logic [F32_FRAC_W-1:0] frac;
  } f32_t;

  // encoding class of a float32 input for a signless target
  typedef enum logic [1:0] {
    CLS_FINITE_POS = 2'd0,
    CLS_ZERO_OUT   = 2'd1,
    CLS_INF_POS    = 2'd2,
    CLS_NAN        = 2'd3
  } f32_cls_e;

endpackage

// File: rtl/f32_classify.sv
module f32_classify
  import rgb_pack_pkg::*;
(
  input  f32_t     f_i,
  output f32_cls_e cls_o
);

  logic exp_ones;
  logic frac_zero;

  assign exp_ones  = &f_i.exp;
  assign frac_zero = ~|f_i.frac;

  // NaN wins over sign; negative values and -Inf clamp to zero
  always_comb begin
    if (exp_ones && !frac_zero) begin
      cls_o = CLS_NAN;
    end else if (f_i.sign) begin
      cls_o = CLS_ZERO_OUT;
    end else if (exp_ones) begin
      cls_o = CLS_INF_POS;
    end else begin
      cls_o = CLS_FINITE_POS;
    end
  end

endmodule

// File: rtl/denorm_shift.sv
module denorm_shift
  import rgb_pack_pkg::*;
#(
  parameter int unsigned MANT_W = 6,
  parameter int unsigned BIAS   = 15
) (
  input  logic [F32_EXP_W-1:0]  exp_i,
  input  logic [F32_FRAC_W-1:0] frac_i,
  output logic [MANT_W-1:0]     mant_o
);

  localparam int unsigned SIG_W = F32_FRAC_W + 1;
  // mant = sig >> (BASE - exp), truncating
  localparam int          BASE  = int'(F32_BIAS) + int'(F32_FRAC_W) - (int'(BIAS) - 1) - int'(MANT_W);

  logic [SIG_W-1:0]   sig;
  logic signed [9:0]  sh_s;
  logic [SIG_W-1:0]   shifted;

  assign sig  = {1'b1, frac_i};
  assign sh_s = 10'(BASE) - $signed({2'b00, exp_i});

  always_comb begin
    shifted = sig >> sh_s[4:0];
    if (exp_i == '0 || sh_s < 0 || sh_s > 10'(SIG_W - 1)) begin
      mant_o = '0;
    end else begin
      mant_o = shifted[MANT_W-1:0];
    end
  end

endmodule

// File: rtl/small_float_cvt.sv
module small_float_cvt
  import rgb_pack_pkg::*;
#(
  parameter int unsigned MANT_W = 6,
  parameter int unsigned EXP_W  = 5
) (
  input  logic [F32_W-1:0]          f_i,
  output logic [MANT_W+EXP_W-1:0]   field_o
);

  localparam int unsigned FIELD_W = MANT_W + EXP_W;
  localparam int unsigned BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int unsigned REBIAS  = F32_BIAS - BIAS;
  localparam int unsigned EXP_MAX = (1 << EXP_W) - 1;

  localparam logic signed [9:0]  EXP_MAX_S = 10'(EXP_MAX);
  localparam logic [EXP_W-1:0]   EXP_ONES  = '1;
  localparam logic [EXP_W-1:0]   EXP_SAT   = EXP_ONES - 1'b1;
  localparam logic [MANT_W-1:0]  MANT_ONES = '1;
  localparam logic [MANT_W-1:0]  MANT_QNAN = MANT_W'(1) << (MANT_W - 1);

  f32_t              f;
  f32_cls_e          cls;
  logic signed [9:0] new_exp;
  logic [MANT_W-1:0] den_mant;
  logic [MANT_W-1:0] norm_mant;

  assign f         = f_i;
  assign new_exp   = $signed({2'b00, f.exp}) - 10'(REBIAS);
  assign norm_mant = f.frac[F32_FRAC_W-1 -: MANT_W];

  f32_classify i_classify (
    .f_i   (f),
    .cls_o (cls)
  );

  denorm_shift #(
    .MANT_W (MANT_W),
    .BIAS   (BIAS)
  ) i_denorm (
    .exp_i  (f.exp),
    .frac_i (f.frac),
    .mant_o (den_mant)
  );

  always_comb begin
    unique case (cls)
      CLS_NAN:      field_o = {EXP_ONES, MANT_QNAN};
      CLS_INF_POS:  field_o = {EXP_ONES, {MANT_W{1'b0}}};
      CLS_ZERO_OUT: field_o = '0;
      default: begin
        if (new_exp >= EXP_MAX_S) begin
          field_o = {EXP_SAT, MANT_ONES};
        end else if (new_exp >= 10'sd1) begin
          field_o = {new_exp[EXP_W-1:0], norm_mant};
        end else begin
          field_o = {{EXP_W{1'b0}}, den_mant};
        end
      end
    endcase
  end

endmodule

// File: rtl/rgb_f32_pack.sv
module rgb_f32_pack
  import rgb_pack_pkg::*;
#(
  parameter int unsigned EXP_W     = 5,
  parameter int unsigned RG_MANT_W = 6,
  parameter int unsigned B_MANT_W  = 5
) (
  input  logic                                                    clk_i,
  input  logic                                                    rst_ni,
  input  logic                                                    valid_i,
  input  logic [31:0]                                             red_i,
  input  logic [31:0]                                             green_i,
  input  logic [31:0]                                             blue_i,
  output logic                                                    valid_o,
  output logic [2*(RG_MANT_W+EXP_W)+(B_MANT_W+EXP_W)-1:0]         packed_o
);

  localparam int unsigned RG_W   = RG_MANT_W + EXP_W;
  localparam int unsigned B_W    = B_MANT_W + EXP_W;
  localparam int unsigned PACK_W = 2 * RG_W + B_W;
  localparam int unsigned N_CH   = 3;

  logic [N_CH-1:0][F32_W-1:0] comp;
  logic [PACK_W-1:0]          packed_nxt;

  assign comp = {blue_i, green_i, red_i};

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int unsigned MW  = (c == N_CH - 1) ? B_MANT_W : RG_MANT_W;
    localparam int unsigned LSB = c * RG_W;
    logic [MW+EXP_W-1:0] field;

    small_float_cvt #(
      .MANT_W (MW),
      .EXP_W  (EXP_W)
    ) i_cvt (
      .f_i     (comp[c]),
      .field_o (field)
    );

    // fixed-width slice keeps each field inside its own bits
    assign packed_nxt[LSB +: MW+EXP_W] = field;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      packed_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        packed_o <= packed_nxt;
      end
    end
  end

endmodule

// File: rtl/rgb_f32_pack_chk.sv
module rgb_f32_pack_chk #(
  parameter int unsigned EXP_W     = 5,
  parameter int unsigned RG_MANT_W = 6,
  parameter int unsigned B_MANT_W  = 5
) (
  input logic                                              clk_i,
  input logic                                              rst_ni,
  input logic                                              valid_i,
  input logic [31:0]                                       red_i,
  input logic [31:0]                                       green_i,
  input logic [31:0]                                       blue_i,
  input logic                                              valid_o,
  input logic [2*(RG_MANT_W+EXP_W)+(B_MANT_W+EXP_W)-1:0]   packed_o
);

  localparam int unsigned RG_W   = RG_MANT_W + EXP_W;
  localparam int unsigned B_W    = B_MANT_W + EXP_W;
  localparam int unsigned PACK_W = 2 * RG_W + B_W;
  localparam logic [B_W-1:0]  B_NAN  = B_W'((((1 << EXP_W) - 1) << B_MANT_W) | (1 << (B_MANT_W - 1)));
  localparam logic [RG_W-1:0] RG_INF = RG_W'(((1 << EXP_W) - 1) << RG_MANT_W);

  a_r9_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r9_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(packed_o));

  a_r2_neg_red_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && red_i[31] && red_i[30:23] != 8'hff) |=> packed_o[RG_W-1:0] == '0);

  a_r3_pinf_red: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && red_i == 32'h7f80_0000) |=> packed_o[RG_W-1:0] == RG_INF);

  a_r4_nan_blue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && blue_i[30:23] == 8'hff && blue_i[22:0] != '0) |=> packed_o[PACK_W-1 -: B_W] == B_NAN);

  a_r5_green_finite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && green_i[30:23] != 8'hff) |=> !(&packed_o[RG_W + RG_MANT_W +: EXP_W]));

endmodule

bind rgb_f32_pack rgb_f32_pack_chk #(
  .EXP_W     (EXP_W),
  .RG_MANT_W (RG_MANT_W),
  .B_MANT_W  (B_MANT_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .red_i    (red_i),
  .green_i  (green_i),
  .blue_i   (blue_i),
  .valid_o  (valid_o),
  .packed_o (packed_o)
);

// File: tb/test_rgb_f32_pack.sv
module test_rgb_f32_pack;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] red_i = '0;
  logic [31:0] green_i = '0;
  logic [31:0] blue_i = '0;
  logic        valid_o;
  logic [31:0] packed_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  rgb_f32_pack i_rgb_f32_pack (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .red_i    (red_i),
    .green_i  (green_i),
    .blue_i   (blue_i),
    .valid_o  (valid_o),
    .packed_o (packed_o)
  );

  // independent model: real-valued magnitude, then search for the field exponent
  function automatic int ref_enc(logic [31:0] f, int mw);
    int  e = int'(f[30:23]);
    int  fr = int'(f[22:0]);
    real v;
    if (e == 255) begin
      if (fr != 0) return (31 << mw) | (1 << (mw - 1));
      return f[31] ? 0 : (31 << mw);
    end
    if (f[31]) return 0;
    if (e == 0) v = real'(fr) * (2.0 ** (-149));
    else        v = (1.0 + real'(fr) / 8388608.0) * (2.0 ** (e - 127));
    if (v >= 65536.0) return (30 << mw) | ((1 << mw) - 1);
    for (int k = 30; k >= 1; k--) begin
      if (v >= 2.0 ** (k - 15))
        return (k << mw) | $rtoi($floor((v / (2.0 ** (k - 15)) - 1.0) * (2.0 ** mw)));
    end
    return $rtoi($floor(v * (2.0 ** (14 + mw))));
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] r, logic [31:0] g, logic [31:0] b);
    @(negedge clk);
    red_i = r; green_i = g; blue_i = b; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic run(string tag, logic [31:0] r, logic [31:0] g, logic [31:0] b,
                     int er, int eg, int eb);
    apply(r, g, b);
    check({tag, " valid"}, int'(valid_o), 1);
    check({tag, " red"},   int'(packed_o[10:0]),  er);
    check({tag, " green"}, int'(packed_o[21:11]), eg);
    check({tag, " blue"},  int'(packed_o[31:22]), eb);
  endtask

  task automatic t_reset;
    check("R11 reset valid", int'(valid_o), 0);
    check("R11 reset word", int'(packed_o), 0);
  endtask

  task automatic t_normal;
    run("R1 normal", 32'h3f80_0000, 32'h3f00_0000, 32'h4040_0000, 'h3c0, 'h380, 'h210);
    check("R1 word", int'(packed_o), (('h210) << 22) | (('h380) << 11) | 'h3c0);
    run("R1 2^-14", 32'h3880_0000, 32'h4700_0000, 32'h3880_0000, 'h040, 'h780, 'h020);
  endtask

  task automatic t_negative;
    run("R2 negative", 32'hbf80_0000, 32'h8000_0000, 32'hc780_0000, 0, 0, 0);
    run("R2 neg denorm", 32'h8000_0001, 32'hb800_0000, 32'h8000_0000, 0, 0, 0);
  endtask

  task automatic t_specials;
    run("R3 inf", 32'h7f80_0000, 32'hff80_0000, 32'h7f80_0000, 'h7c0, 0, 'h3e0);
    run("R4 nan", 32'h7fc0_0000, 32'hffc0_0001, 32'hff80_0001, 'h7e0, 'h7e0, 'h3f0);
  endtask

  task automatic t_saturate;
    run("R5 max finite", 32'h477e_0000, 32'h477e_0000, 32'h477c_0000, 'h7bf, 'h7bf, 'h3df);
    run("R5 saturate", 32'h4780_0000, 32'h7f7f_ffff, 32'h477e_0000, 'h7bf, 'h7bf, 'h3df);
  endtask

  task automatic t_trunc;
    run("R6 truncate", 32'h3fff_ffff, 32'h3f81_0000, 32'h3f83_ffff, 'h3ff, 'h3c0, 'h1e0);
  endtask

  task automatic t_denorm;
    run("R7 denorm", 32'h3800_0000, 32'h3580_0000, 32'h3600_0000, 'h020, 'h001, 'h001);
    run("R7 underflow", 32'h3500_0000, 32'h0000_0001, 32'h3580_0000, 0, 0, 0);
    run("R7 below 2^-14", 32'h387f_ffff, 32'h387f_ffff, 32'h387f_ffff, 'h03f, 'h03f, 'h01f);
  endtask

  task automatic t_indep;
    run("R8 isolate", 32'h3800_0000, 32'h0000_0000, 32'h7f80_0000, 'h020, 0, 'h3e0);
    run("R8 isolate2", 32'h0000_0000, 32'h7fff_ffff, 32'h0000_0000, 0, 'h7e0, 0);
  endtask

  task automatic t_hold;
    logic [31:0] prev;
    apply(32'h3f80_0000, 32'h3f80_0000, 32'h3f80_0000);
    prev = packed_o;
    @(negedge clk);
    red_i = 32'h7f80_0000; green_i = 32'hbf80_0000; blue_i = 32'h4000_0000;
    @(negedge clk);
    check("R9 valid low", int'(valid_o), 0);
    check("R10 hold", int'(packed_o), int'(prev));
  endtask

  task automatic t_async_reset;
    apply(32'h3f80_0000, 32'h3f80_0000, 32'h3f80_0000);
    #3 rst_ni = 1'b0;
    #2;
    check("R11 async valid", int'(valid_o), 0);
    check("R11 async word", int'(packed_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_sweep;
    logic [31:0] s = 32'h1234_5678;
    logic [31:0] v[3];
    for (int i = 0; i < 300; i++) begin
      for (int c = 0; c < 3; c++) begin
        s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
        v[c] = s ^ {s[7:0], s[31:8]};
        if (i % 4 == 1) v[c][30:27] = 4'b0111;
        if (i % 4 == 2) v[c][30:26] = 5'b01110;
      end
      apply(v[0], v[1], v[2]);
      check("R1 sweep red",   int'(packed_o[10:0]),  ref_enc(v[0], 6));
      check("R1 sweep green", int'(packed_o[21:11]), ref_enc(v[1], 6));
      check("R1 sweep blue",  int'(packed_o[31:22]), ref_enc(v[2], 5));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_normal();
    t_negative();
    t_specials();
    t_saturate();
    t_trunc();
    t_denorm();
    t_indep();
    t_hold();
    t_async_reset();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule